// File: doc/BRIEF.md
# Compare-Clear Interval Timer and Event Counter

This block is a 16-bit up-counter with a software-loaded compare value. Each cycle it receives a count enable from one of two sources. In timer operation it uses an internal prescaler that divides the core clock by 1, 4, 16 or 256. In event operation it uses a selected edge on an external event pin, taken through a two-flop synchronizer. When the counter reaches the compare value and another count enable arrives, the counter returns to zero. In the same cycle it issues a one-clock interrupt pulse and sets a sticky interrupt flag. For compare value N, one period is N + 1 count enables.

Software programs the block through a small write-only register port. The usual order is: choose the prescaler and the edge, load the compare value, then write the operating mode to start the counter. The compare register has no shadow copy, so a new value is used from the next count enable on. If the new value is below the live count, the counter does not match on the way down. It runs up to FFFFH, wraps to 0000H and matches only when it reaches the new value. To use a lowered value at once, software rewrites the mode, which restarts the count from zero.

A three-state machine controls the counter. The states are IDLE (counter held at zero), TIMER (counting prescaler ticks) and EVENT (counting pin edges). The transitions are:
- START_TIMER: a mode write of 1 moves the machine to TIMER.
- START_EVENT: a mode write of 2 moves the machine to EVENT.
- STOP: a mode write of 0 or 3 moves the machine to IDLE.
- RESTART: any mode write made while running clears the count and the prescaler in that cycle and enters the written state.

Top module: `cmp_interval_timer`

## Requirements
- R1: After reset, count_out is 0000H, irq_pulse and irq_flag are 0, the machine is in IDLE, the compare value is FFFFH, the prescaler code is 0 and the edge select is rising.
- R2: In TIMER state the count rises by one on each prescaler tick. Register address 1, bits [1:0], selects the division: codes 0, 1, 2 and 3 give 1, 4, 16 and 256. A start write at clock edge E0 makes the first tick arrive at edge E0 + D, and one full period lasts (N + 1) × D clocks.
- R3: On a count enable while count_out equals the compare value, count_out becomes 0000H and irq_pulse is high for exactly that one cycle.
- R4: irq_flag is set together with irq_pulse and stays set. Writing 1 to bit 0 at address 3 clears it. Writing 0 there has no effect. A set in the same cycle as a clear wins.
- R5: A write of 0000H to the compare register (address 2) is ignored, and the previous compare value stays in force.
- R6: A compare value written below the live count takes effect without a shadow copy. No match occurs until the count has passed FFFFH and wrapped to 0000H.
- R7: A write to address 0 with bits [1:0] = 0 or 3 stops the counter and holds count_out at 0000H with no pulse. A write of 1 (timer) or 2 (event) starts the counter, or restarts it, from 0000H.
- R8: In EVENT state the count rises once for each selected edge of evt_in. Bit 2 at address 1 selects the edge: 0 for rising, 1 for falling. The increment appears at the third clock edge after the pin changes. Edges of the other polarity do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 mode, 1 prescaler/edge, 2 compare, 3 flag clear |
| wr_data | input | 16 | Write data |
| evt_in | input | 1 | Asynchronous external event pin |
| count_out | output | 16 | Live counter value |
| irq_pulse | output | 1 | One-cycle match interrupt |
| irq_flag | output | 1 | Sticky match flag |

## Verification
A register write acts at the clock edge where it is sampled. A start write at edge E0 therefore gives the first interrupt at edge E0 + (N + 1) × D. The bench drives inputs on falling edges and counts falling edges after each write until the pulse appears, so the counted number equals the expected edge count exactly. For a lowered compare value, the bench reads the live count V just after the write and expects the pulse 65536 − V + M + 1 cycles later. For event inputs the increment is due on the third rising edge after the pin changes, so the bench samples four falling edges after each pin change.

// File: rtl/ct_pkg.sv
package ct_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TIMER = 2'd1,
        ST_EVENT = 2'd2
    } ct_state_e;

    localparam logic [1:0] ADDR_MODE  = 2'd0;
    localparam logic [1:0] ADDR_CLKSEL = 2'd1;
    localparam logic [1:0] ADDR_CMP   = 2'd2;
    localparam logic [1:0] ADDR_FLAG  = 2'd3;

    localparam logic [1:0] MODE_TIMER = 2'd1;
    localparam logic [1:0] MODE_EVENT = 2'd2;
endpackage

// File: rtl/ct_prescaler.sv
module ct_prescaler #(
    parameter int CNT_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [CNT_W-1:0] div_cnt;
    logic [CNT_W-1:0] mask;

    // divide by 1, 4, 16, 256: low 0, 2, 4 or 8 bits all ones
    always_comb begin
        unique case (sel)
            2'd0:    mask = '0;
            2'd1:    mask = CNT_W'(8'h03);
            2'd2:    mask = CNT_W'(8'h0F);
            default: mask = CNT_W'(8'hFF);
        endcase
    end

    assign tick = !clear && ((div_cnt & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     div_cnt <= '0;
        else if (clear) div_cnt <= '0;
        else            div_cnt <= div_cnt + CNT_W'(1);
    end
endmodule

// File: rtl/ct_edge_detect.sv
module ct_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic falling,
    output logic edge_hit
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[s] <= 1'b0;
                    else        sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign edge_hit = falling ? (prev_q && !sync_q[SYNC_STAGES-1])
                              : (!prev_q && sync_q[SYNC_STAGES-1]);

    // R8: a selected edge needs the synced level to change twice before it can repeat
    a_r8_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> !edge_hit);
endmodule

// File: rtl/ct_count_core.sv
module ct_count_core #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] count,
    output logic         pulse,
    output logic         hit
);
    assign hit = tick && !clear && (count == cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            pulse <= 1'b0;
        end else if (clear) begin
            count <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= hit;
            if (tick) count <= hit ? '0 : count + W'(1);
        end
    end

    a_r3_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear && count == cmp) |=> (count == '0 && pulse));
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !clear && count != cmp) |=> (count == $past(count) + W'(1)));
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (count == '0 && !pulse));
    a_r2_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> $stable(count));
endmodule

// File: rtl/cmp_interval_timer.sv
module cmp_interval_timer
    import ct_pkg::*;
#(
    parameter int W           = 16,
    parameter int PRESC_W     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   wr_addr,
    input  logic [W-1:0] wr_data,
    input  logic         evt_in,
    output logic [W-1:0] count_out,
    output logic         irq_pulse,
    output logic         irq_flag
);
    ct_state_e    state_q, state_d;
    logic [W-1:0] cmp_q;
    logic [1:0]   div_sel_q;
    logic         falling_q;

    logic mode_wr, flag_clr;
    logic presc_clear, core_clear, count_tick;
    logic presc_tick, evt_edge, match_hit;

    assign mode_wr  = wr_en && (wr_addr == ADDR_MODE);
    assign flag_clr = wr_en && (wr_addr == ADDR_FLAG) && wr_data[0];

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q     <= '1;
            div_sel_q <= 2'd0;
            falling_q <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CLKSEL) begin
                div_sel_q <= wr_data[1:0];
                falling_q <= wr_data[2];
            end
            if (wr_addr == ADDR_CMP && wr_data != '0) cmp_q <= wr_data;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: START_TIMER, START_EVENT, STOP, RESTART
    always_comb begin
        state_d = state_q;
        if (mode_wr) begin
            unique case (wr_data[1:0])
                MODE_TIMER: state_d = ST_TIMER;
                MODE_EVENT: state_d = ST_EVENT;
                default:    state_d = ST_IDLE;
            endcase
        end
    end

    // state outputs
    always_comb begin
        presc_clear = 1'b1;
        core_clear  = mode_wr;
        count_tick  = 1'b0;
        unique case (state_q)
            ST_TIMER: begin
                presc_clear = mode_wr;
                count_tick  = presc_tick;
            end
            ST_EVENT: count_tick = evt_edge;
            default:  core_clear = 1'b1;
        endcase
    end

    ct_prescaler #(.CNT_W(PRESC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .clear(presc_clear),
        .sel(div_sel_q), .tick(presc_tick)
    );

    ct_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin(evt_in),
        .falling(falling_q), .edge_hit(evt_edge)
    );

    ct_count_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .clear(core_clear), .tick(count_tick),
        .cmp(cmp_q), .count(count_out), .pulse(irq_pulse), .hit(match_hit)
    );

    // sticky flag, set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         irq_flag <= 1'b0;
        else if (match_hit) irq_flag <= 1'b1;
        else if (flag_clr)  irq_flag <= 1'b0;
    end

    a_r5_cmp_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_q != '0);
    a_r4_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> irq_flag);
    a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (count_out == '0 && !irq_pulse));
endmodule

// File: tb/cmp_interval_timer_test.sv
module cmp_interval_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        evt_in = 1'b0;
    logic [15:0] count_out;
    logic        irq_pulse, irq_flag;

    int n_checks = 0;
    int n_fail = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    cmp_interval_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .evt_in(evt_in), .count_out(count_out),
        .irq_pulse(irq_pulse), .irq_flag(irq_flag)
    );

    localparam int NV = 5;
    localparam logic [1:0]  V_DIV [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd0};
    localparam logic [15:0] V_CMP [NV] = '{16'd3, 16'd2, 16'd1, 16'd1, 16'd200};
    localparam int          V_EXP [NV] = '{4, 12, 32, 512, 201};

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_pulse(input int limit, output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!irq_pulse && k < limit);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            finish_run();
        end
    end

    initial begin
        int k, v;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 count", count_out, 0);
        chk("R1 pulse", irq_pulse, 0);
        chk("R1 flag", irq_flag, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle count", count_out, 0);

        // R2/R3 vector table: period (N+1)*D
        for (int i = 0; i < NV; i++) begin
            wr(2'd1, {14'd0, V_DIV[i]});
            wr(2'd2, V_CMP[i]);
            wr(2'd0, 16'd1);
            wait_pulse(2000, k);
            chk("R2 first period", k, V_EXP[i]);
            chk("R3 cleared at pulse", count_out, 0);
            wait_pulse(2000, k);
            chk("R2 repeat period", k, V_EXP[i]);
            @(negedge clk);
            chk("R3 pulse one cycle", irq_pulse, 0);
            wr(2'd0, 16'd0);
        end

        // R4 sticky flag
        chk("R4 flag sticky", irq_flag, 1);
        wr(2'd3, 16'd0);
        chk("R4 write 0 keeps", irq_flag, 1);
        wr(2'd3, 16'd1);
        chk("R4 write 1 clears", irq_flag, 0);

        // R5 zero compare ignored
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd5);
        wr(2'd2, 16'd0);
        wr(2'd0, 16'd1);
        wait_pulse(2000, k);
        chk("R5 zero write ignored", k, 6);

        // R7 stop holds zero, code 3 also stops
        repeat (2) @(negedge clk);
        wr(2'd0, 16'd0);
        repeat (20) @(negedge clk);
        chk("R7 stop holds 0", count_out, 0);
        chk("R7 no pulse stopped", irq_pulse, 0);
        wr(2'd0, 16'd1);
        repeat (3) @(negedge clk);
        wr(2'd0, 16'd3);
        repeat (10) @(negedge clk);
        chk("R7 code 3 stops", count_out, 0);

        // R6 lowered compare wraps through FFFFH
        wr(2'd2, 16'd100);
        wr(2'd0, 16'd1);
        repeat (60) @(negedge clk);
        wr(2'd2, 16'd10);
        v = count_out;
        wait_pulse(70000, k);
        chk("R6 wrap before match", k, 65536 - v + 11);
        // R7 restart applies lowered value at once
        wr(2'd0, 16'd1);
        wait_pulse(2000, k);
        chk("R7 restart period", k, 11);
        wr(2'd0, 16'd0);

        // R8 event counting, rising edges
        wr(2'd3, 16'd1);
        wr(2'd1, 16'd0);
        wr(2'd2, 16'd3);
        wr(2'd0, 16'd2);
        for (int e = 0; e < 4; e++) begin
            evt_in = 1'b1;
            repeat (4) @(negedge clk);
            chk("R8 rising counts", count_out, (e + 1) % 4);
            evt_in = 1'b0;
            repeat (4) @(negedge clk);
            chk("R8 falling ignored", count_out, (e + 1) % 4);
        end
        chk("R8 match sets flag", irq_flag, 1);

        // R8 falling edge select
        wr(2'd1, 16'd4);
        wr(2'd0, 16'd2);
        evt_in = 1'b1;
        repeat (4) @(negedge clk);
        chk("R8 rising ignored", count_out, 0);
        evt_in = 1'b0;
        repeat (4) @(negedge clk);
        chk("R8 falling counts", count_out, 1);

        finish_run();
    end
endmodule